// File: doc/BRIEF.md
# Endian-Selectable Load/Store Aligner

This block sits between a 32-bit register datapath and a memory port that only moves whole 32-bit words. On a load it receives the fetched word together with the two low address bits and the access size. It picks out the addressed bytes, moves them down to the least significant end, and widens the result to 32 bits with either sign or zero fill. On a store it moves the low bytes of the register value up into the addressed byte lanes and produces a four-bit lane write mask. The block accepts byte, halfword, three-byte (triplet) and full-word accesses.

The native byte order is taken from a strap input while reset is held and stays fixed until the next reset. A reverse-order control bit flips that order for each access, but only when the request is marked as coming from user mode. Kernel-mode accesses always use the native order. Misaligned requests are flagged and produce no lane writes. All results are registered and appear one clock after the request.

Top module: `lsu_lane_aligner`

## Requirements
- R1: While rst_n is low the native order is loaded from boot_big_endian_i (1 = big endian). After reset release it keeps that value even if the strap changes.
- R2: The order used for an access is the native order inverted when user_mode_i and rev_order_i are both 1. With user_mode_i low the rev_order_i input has no effect.
- R3: req_size_i encodes 00 byte, 01 halfword, 10 triplet, 11 word. A byte load at offset o reads byte lane o (little endian) or lane 3-o (big endian), where lane k is bits 8k+7:8k. The result lands in bits 7:0.
- R4: A halfword load at an even offset o returns bits 8o+15:8o in little endian, or bits 31-8o down to 16-8o in big endian.
- R5: A triplet load is legal at offsets 0 and 1. It returns bits 8o+23:8o (little endian) or bits 31-8o down to 8-8o (big endian), always zero-extended.
- R6: For byte and halfword loads, req_sext_i = 1 copies the top bit of the selected data into the upper bits and req_sext_i = 0 fills them with zeros.
- R7: A word access at offset 0 passes the data through unchanged. A word store enables all four lanes.
- R8: A store places data bytes 0..n-1 in the same lanes that a load of the same size, offset and order would read, ordered the same way. byte_en_o is set for exactly those lanes and store_data_o is zero in every other lane.
- R9: A halfword at an odd offset, a triplet at offset 2 or 3, or a word at a nonzero offset raises align_err_o for one cycle. Such a request gives byte_en_o = 0 and asserts neither valid output.
- R10: Outputs update on the clock edge that samples req_valid_i. A cycle without a request gives zero valids, error and lane mask while the data outputs hold. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_big_endian_i | input | 1 | Native order strap, sampled during reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size code |
| req_sext_i | input | 1 | Sign-extend byte/halfword load results |
| req_off_i | input | 2 | Byte offset within the word |
| user_mode_i | input | 1 | Request issued in user mode |
| rev_order_i | input | 1 | Reverse-order status bit |
| mem_rdata_i | input | 32 | Word fetched from memory |
| reg_wdata_i | input | 32 | Register value to store |
| load_valid_o | output | 1 | Aligned load data valid |
| load_data_o | output | 32 | Aligned, extended load result |
| store_valid_o | output | 1 | Store data and lanes valid |
| store_data_o | output | 32 | Store word placed into lanes |
| byte_en_o | output | 4 | Per-lane write enables |
| align_err_o | output | 1 | Misaligned request |

## Verification
The checker watches, on every cycle, the rules that hold whatever the data is. An error excludes both valids and every lane enable. Lane enables appear only with a valid store. An idle cycle gives quiet outputs, a byte store enables exactly one lane, and a word store enables all four. Odd halfwords always fault, an unsigned byte load leaves the upper bits zero, and the latched native order never moves after reset. The actual byte chosen for each offset, the mirroring under the two orders, the kernel/user gating of the reverse bit and the strap capture can only be shown by the bench's scenarios. These compare returned values against words with distinct lanes.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_TRIP = 2'd2,
    SZ_WORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lane_map.sv
// Turns size, offset and byte order into a lane shift, a lane mask and a
// misalignment flag.
module lane_map
  import lsu_align_pkg::*;
#(
  parameter int LANES_P = 4,
  parameter int OFF_W_P = 2
) (
  input  acc_size_e            size_i,
  input  logic [OFF_W_P-1:0]   off_i,
  input  logic                 big_i,
  output logic [OFF_W_P-1:0]   shift_o,
  output logic [LANES_P-1:0]   lanes_o,
  output logic                 mis_o
);
  localparam int CW = OFF_W_P + 2;

  logic [CW-1:0] nbytes;
  logic [CW-1:0] off_w;
  logic [CW-1:0] shift_w;

  always_comb begin
    nbytes  = CW'(size_i) + CW'(1);
    off_w   = CW'(off_i);
    mis_o   = ((off_w + nbytes) > CW'(LANES_P)) || ((size_i == SZ_HALF) && off_i[0]);
    shift_w = big_i ? (CW'(LANES_P) - nbytes - off_w) : off_w;
    shift_o = shift_w[OFF_W_P-1:0];
  end

  for (genvar k = 0; k < LANES_P; k++) begin : g_lane
    assign lanes_o[k] = !mis_o && (CW'(k) >= shift_w) && (CW'(k) < (shift_w + nbytes));
  end
endmodule

// File: rtl/load_extract.sv
// Moves the selected bytes down to bit 0 and widens them.
module load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W_P = 32,
  parameter int OFF_W_P  = 2
) (
  input  logic [DATA_W_P-1:0] word_i,
  input  logic [OFF_W_P-1:0]  shift_i,
  input  acc_size_e           size_i,
  input  logic                sext_i,
  output logic [DATA_W_P-1:0] data_o
);
  logic [DATA_W_P-1:0] shifted;

  always_comb begin
    shifted = word_i >> {shift_i, 3'b000};
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W_P-8){sext_i & shifted[7]}}, shifted[7:0]};
      SZ_HALF: data_o = {{(DATA_W_P-16){sext_i & shifted[15]}}, shifted[15:0]};
      SZ_TRIP: data_o = {{(DATA_W_P-24){1'b0}}, shifted[23:0]};
      default: data_o = shifted;
    endcase
  end
endmodule

// File: rtl/store_place.sv
// Moves register bytes up into the addressed lanes and clears the rest.
module store_place #(
  parameter int DATA_W_P = 32,
  parameter int LANES_P  = 4,
  parameter int OFF_W_P  = 2
) (
  input  logic [DATA_W_P-1:0] data_i,
  input  logic [OFF_W_P-1:0]  shift_i,
  input  logic [LANES_P-1:0]  lanes_i,
  output logic [DATA_W_P-1:0] data_o
);
  logic [DATA_W_P-1:0] moved;

  assign moved = data_i << {shift_i, 3'b000};

  for (genvar k = 0; k < LANES_P; k++) begin : g_lane
    assign data_o[8*k +: 8] = lanes_i[k] ? moved[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
  import lsu_align_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_big_endian_i,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_sext_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic              user_mode_i,
  input  logic              rev_order_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              store_valid_o,
  output logic [DATA_W-1:0] store_data_o,
  output logic [LANES-1:0]  byte_en_o,
  output logic              align_err_o
);
  acc_size_e         size;
  logic              base_be_q;
  logic              eff_big;
  logic [OFF_W-1:0]  shift;
  logic [LANES-1:0]  lanes;
  logic              mis;
  logic [DATA_W-1:0] ld_word;
  logic [DATA_W-1:0] st_word;

  logic              ld_vld_d, st_vld_d, err_d;
  logic [LANES-1:0]  be_d;
  logic              data_en;

  assign size    = acc_size_e'(req_size_i);
  assign eff_big = base_be_q ^ (rev_order_i & user_mode_i);

  lane_map #(.LANES_P(LANES), .OFF_W_P(OFF_W)) u_map (
    .size_i  (size),
    .off_i   (req_off_i),
    .big_i   (eff_big),
    .shift_o (shift),
    .lanes_o (lanes),
    .mis_o   (mis)
  );

  load_extract #(.DATA_W_P(DATA_W), .OFF_W_P(OFF_W)) u_load (
    .word_i  (mem_rdata_i),
    .shift_i (shift),
    .size_i  (size),
    .sext_i  (req_sext_i),
    .data_o  (ld_word)
  );

  store_place #(.DATA_W_P(DATA_W), .LANES_P(LANES), .OFF_W_P(OFF_W)) u_store (
    .data_i  (reg_wdata_i),
    .shift_i (shift),
    .lanes_i (lanes),
    .data_o  (st_word)
  );

  always_comb begin
    ld_vld_d = req_valid_i && !req_store_i && !mis;
    st_vld_d = req_valid_i &&  req_store_i && !mis;
    err_d    = req_valid_i && mis;
    be_d     = (req_valid_i && req_store_i) ? lanes : '0;
    data_en  = req_valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_be_q     <= boot_big_endian_i;
      load_valid_o  <= 1'b0;
      store_valid_o <= 1'b0;
      align_err_o   <= 1'b0;
      byte_en_o     <= '0;
      load_data_o   <= '0;
      store_data_o  <= '0;
    end else begin
      load_valid_o  <= ld_vld_d;
      store_valid_o <= st_vld_d;
      align_err_o   <= err_d;
      byte_en_o     <= be_d;
      if (data_en) begin
        load_data_o  <= ld_word;
        store_data_o <= st_word;
      end
    end
  end
endmodule

// File: rtl/lsu_lane_aligner_chk.sv
module lsu_lane_aligner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic        req_store_i,
  input logic [1:0]  req_size_i,
  input logic        req_sext_i,
  input logic [1:0]  req_off_i,
  input logic        load_valid_o,
  input logic [31:0] load_data_o,
  input logic        store_valid_o,
  input logic [3:0]  byte_en_o,
  input logic        align_err_o,
  input logic        base_be_q
);
  // R1
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(base_be_q));

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> (!load_valid_o && !store_valid_o && byte_en_o == 4'h0));

  // R9
  half_odd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_size_i == 2'd1 && req_off_i[0]) |=> align_err_o);

  // R8
  be_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en_o != 4'h0) |-> store_valid_o);

  // R8
  byte_store_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_store_i && req_size_i == 2'd0) |=> ($countones(byte_en_o) == 1));

  // R7
  word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_store_i && req_size_i == 2'd3 && req_off_i == 2'd0) |=> (byte_en_o == 4'hF));

  // R3
  byte_load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_store_i && req_size_i == 2'd0) |=> load_valid_o);

  // R6
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_store_i && !req_sext_i && req_size_i == 2'd0) |=> (load_data_o[31:8] == 24'h0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!load_valid_o && !store_valid_o && !align_err_o && byte_en_o == 4'h0));
endmodule

bind lsu_lane_aligner lsu_lane_aligner_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid_i   (req_valid_i),
  .req_store_i   (req_store_i),
  .req_size_i    (req_size_i),
  .req_sext_i    (req_sext_i),
  .req_off_i     (req_off_i),
  .load_valid_o  (load_valid_o),
  .load_data_o   (load_data_o),
  .store_valid_o (store_valid_o),
  .byte_en_o     (byte_en_o),
  .align_err_o   (align_err_o),
  .base_be_q     (base_be_q)
);

// File: tb/lsu_lane_aligner_tb.sv
module lsu_lane_aligner_tb;
  logic        clk;
  logic        rst_n;
  logic        boot_big_endian_i;
  logic        req_valid_i, req_store_i, req_sext_i;
  logic [1:0]  req_size_i, req_off_i;
  logic        user_mode_i, rev_order_i;
  logic [31:0] mem_rdata_i, reg_wdata_i;
  logic        load_valid_o, store_valid_o, align_err_o;
  logic [31:0] load_data_o, store_data_o;
  logic [3:0]  byte_en_o;

  int checks = 0;
  int fails  = 0;

  lsu_lane_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .boot_big_endian_i(boot_big_endian_i),
    .req_valid_i(req_valid_i), .req_store_i(req_store_i), .req_size_i(req_size_i),
    .req_sext_i(req_sext_i), .req_off_i(req_off_i), .user_mode_i(user_mode_i),
    .rev_order_i(rev_order_i), .mem_rdata_i(mem_rdata_i), .reg_wdata_i(reg_wdata_i),
    .load_valid_o(load_valid_o), .load_data_o(load_data_o), .store_valid_o(store_valid_o),
    .store_data_o(store_data_o), .byte_en_o(byte_en_o), .align_err_o(align_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        sx;
    logic        um;
    logic        rv;
    logic [1:0]  off;
    logic [31:0] din;
    logic [31:0] exp;
    logic [3:0]  be;
    logic        er;
  } vec_t;

  localparam logic [31:0] MW = 32'h9E8C70F5;
  localparam logic [31:0] RW = 32'h11223344;
  localparam int NV = 27;

  // Native order is little endian for the whole table; um+rv selects big endian.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, MW, 32'hFFFFFFF5, 4'h0, 1'b0},
    '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, MW, 32'h00000070, 4'h0, 1'b0},
    '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, MW, 32'hFFFFFF8C, 4'h0, 1'b0},
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, MW, 32'h0000009E, 4'h0, 1'b0},
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, MW, 32'h000070F5, 4'h0, 1'b0},
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2, MW, 32'hFFFF9E8C, 4'h0, 1'b0},
    '{1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 2'd1, MW, 32'h009E8C70, 4'h0, 1'b0},
    '{1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, MW, 32'h9E8C70F5, 4'h0, 1'b0},
    '{1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 2'd0, MW, 32'hFFFFFF9E, 4'h0, 1'b0},
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 2'd3, MW, 32'h000000F5, 4'h0, 1'b0},
    '{1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 2'd0, MW, 32'h00009E8C, 4'h0, 1'b0},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 2'd2, MW, 32'h000070F5, 4'h0, 1'b0},
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 2'd0, MW, 32'h009E8C70, 4'h0, 1'b0},
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 2'd1, MW, 32'h008C70F5, 4'h0, 1'b0},
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, MW, 32'h000000F5, 4'h0, 1'b0},
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, MW, 32'h000000F5, 4'h0, 1'b0},
    '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, RW, 32'h00004400, 4'h2, 1'b0},
    '{1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 2'd1, RW, 32'h00440000, 4'h4, 1'b0},
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, RW, 32'h33440000, 4'hC, 1'b0},
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 2'd2, RW, 32'h00003344, 4'h3, 1'b0},
    '{1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1, RW, 32'h22334400, 4'hE, 1'b0},
    '{1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 2'd1, RW, 32'h00223344, 4'h7, 1'b0},
    '{1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, RW, 32'h11223344, 4'hF, 1'b0},
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, MW, 32'h00000000, 4'h0, 1'b1},
    '{1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2, RW, 32'h00000000, 4'h0, 1'b1},
    '{1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd2, MW, 32'h00000000, 4'h0, 1'b1},
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 2'd3, RW, 32'h00000000, 4'h0, 1'b1}
  };

  function automatic string tag_of(vec_t v);
    if (v.er)               return "R9";
    if (v.sz == 2'd3)       return "R7";
    if (v.st)               return "R8";
    if (v.um || v.rv)       return "R2";
    if (v.sz == 2'd2)       return "R5";
    if (v.sz == 2'd1)       return "R4 R6";
    return "R3 R6";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic sx, input logic um,
                       input logic rv, input logic [1:0] off, input logic [31:0] din);
    req_valid_i = 1'b1;
    req_store_i = st;
    req_size_i  = sz;
    req_sext_i  = sx;
    user_mode_i = um;
    rev_order_i = rv;
    req_off_i   = off;
    mem_rdata_i = st ? 32'hDEAD_BEEF : din;
    reg_wdata_i = st ? din : 32'hCAFE_F00D;
  endtask

  task automatic idle();
    req_valid_i = 1'b0;
    req_store_i = 1'b0;
    req_size_i  = 2'd0;
    req_sext_i  = 1'b0;
    user_mode_i = 1'b0;
    rev_order_i = 1'b0;
    req_off_i   = 2'd0;
    mem_rdata_i = 32'h0;
    reg_wdata_i = 32'h0;
  endtask

  task automatic do_reset(input logic strap);
    idle();
    boot_big_endian_i = strap;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    do_reset(1'b0);

    // R10: reset state
    check({load_valid_o, store_valid_o, align_err_o, byte_en_o} == 7'h0, "R10",
          64'({load_valid_o, store_valid_o, align_err_o, byte_en_o}), 64'h0);
    check(load_data_o == 32'h0 && store_data_o == 32'h0, "R10",
          {load_data_o, store_data_o}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.st, v.sz, v.sx, v.um, v.rv, v.off, v.din);
      @(negedge clk);
      check({load_valid_o, store_valid_o, align_err_o, byte_en_o} ==
            {!v.st && !v.er, v.st && !v.er, v.er, v.be}, tag_of(v),
            64'({load_valid_o, store_valid_o, align_err_o, byte_en_o}),
            64'({!v.st && !v.er, v.st && !v.er, v.er, v.be}));
      if (!v.er) begin
        if (v.st) check(store_data_o == v.exp, tag_of(v), 64'(store_data_o), 64'(v.exp));
        else      check(load_data_o  == v.exp, tag_of(v), 64'(load_data_o),  64'(v.exp));
      end
    end

    // R10: idle cycle is quiet and data holds
    drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, MW);
    @(negedge clk);
    held = load_data_o;
    idle();
    @(negedge clk);
    check({load_valid_o, store_valid_o, align_err_o, byte_en_o} == 7'h0, "R10",
          64'({load_valid_o, store_valid_o, align_err_o, byte_en_o}), 64'h0);
    check(load_data_o == held && held == 32'h00000070, "R10", 64'(load_data_o), 64'h70);

    // R1: big-endian strap, then strap changes after reset
    do_reset(1'b1);
    boot_big_endian_i = 1'b0;
    drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, MW);
    @(negedge clk);
    check(load_data_o == 32'h0000009E, "R1", 64'(load_data_o), 64'h9E);
    drive(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, RW);
    @(negedge clk);
    check(store_data_o == 32'h33440000 && byte_en_o == 4'hC, "R1 R8",
          {store_data_o, 28'h0, byte_en_o}, {32'h33440000, 32'hC});

    // R2: big-endian native, user + reverse gives little endian
    drive(1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 2'd0, MW);
    @(negedge clk);
    check(load_data_o == 32'h000000F5, "R2", 64'(load_data_o), 64'hF5);
    // R2: kernel mode ignores the reverse bit
    drive(1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 2'd2, MW);
    @(negedge clk);
    check(load_data_o == 32'h000070F5, "R2 R4", 64'(load_data_o), 64'h70F5);
    idle();
    @(negedge clk);

    finish_run();
  end
endmodule